// File: doc/BRIEF.md
# DDR SDRAM Command Sequencing Monitor

This block watches the command lines of a DDR SDRAM controller and checks each command against a small set of ordering rules. It decodes chip select, the three strobe lines, the bank address and the address bus once per clock. From that it keeps three pieces of state: which banks hold an open row, how long ago a mode register was last loaded, and how long ago the DLL was last switched on. It drives nothing onto the memory bus.

When the controller breaks a rule, the monitor sets a sticky error flag and a three-bit code that names the first violation. Both stay set until a one-cycle clear. The monitor also reports the DLL and output-drive settings most recently written to the extended mode register, and the set of open banks. The violating command still updates the tracked state, the same way the memory would act on it.

Top module: `ddr_cmd_checker`

## Requirements
- R1: After a synchronous active-low reset, `err_flag` is 0, `err_code` is 0, `bank_open` is 0, `dll_enabled` is 0 and `drive_reduced` is 0.
- R2: Commands decode from {cs_n, ras_n, cas_n, we_n}. 1xxx is deselect and 0111 is no-operation. Neither one changes any tracked state or output, and neither is ever flagged, including inside the mode-load gap. Every other pattern is an executable command.
- R3: ACTIVE (0011) sets `bank_open[ba]`. PRECHARGE (0010) clears every bit when addr[10]=1, and otherwise clears only `bank_open[ba]`. Each change is visible one cycle after the command.
- R4: READ (0101) or WRITE (0100) to a bank whose `bank_open` bit is 0 is a violation with code 5.
- R5: LOAD MODE (0000) issued while any bank is open is a violation with code 1.
- R6: Any executable command issued fewer than TMRD cycles after a LOAD MODE (default 2) is a violation with code 2.
- R7: LOAD MODE with ba=01 targets the extended register. It sets `dll_enabled` = ~addr[0] and `drive_reduced` = addr[1]. LOAD MODE with ba=00, 10 or 11 leaves both outputs unchanged.
- R8: An extended-register load with any of addr[12:2] nonzero is a violation with code 4.
- R9: If an extended load changes the DLL from disabled to enabled at cycle t, a READ at any cycle before t+TLOCK (default 200) is a violation with code 3. A READ at t+TLOCK is legal.
- R10: `err_flag` and `err_code` update one cycle after the violating command. They hold the first violation until `clr_err` is 1, and a clear in the same cycle as a violation wins. When several rules break at once, the recorded code is chosen in this priority order: 2, then 1, then 4, then 5, then 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Clears the sticky error state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| dll_enabled | output | 1 | DLL setting last written |
| drive_reduced | output | 1 | Drive-strength setting last written |

## Verification
The bench targets the edges of both windows. It issues a command one cycle after a mode load and a READ exactly TLOCK-1 and TLOCK cycles after the DLL is enabled. A counter that is off by one would flag the legal READ or miss the early one. It also breaks two rules in the same cycle and clears in the same cycle as a violation. A wrong priority or a clear that loses to the error would leave the wrong code latched. Last, it sends loads to the base and the undefined register targets, where a design that does not check the bank address would overwrite the DLL and drive settings.

// File: rtl/ddr_chk_pkg.sv
// Package: command and violation-code types shared by the checker modules.
package ddr_chk_pkg;
    typedef enum logic [2:0] {
        CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_LMR, CMD_OTHER
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE        = 3'd0,
        ERR_LMR_BUSY    = 3'd1,
        ERR_MRD_GAP     = 3'd2,
        ERR_DLL_LOCK    = 3'd3,
        ERR_EMR_RSVD    = 3'd4,
        ERR_BANK_CLOSED = 3'd5
    } err_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
// Module: ddr_cmd_decode
// Turns the four active-low strobe lines into a command class.
// Assumes: pure combinational, no state; chip select high hides the other lines.
module ddr_cmd_decode
    import ddr_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // Map the strobe pattern to a command class.
    always_comb begin
        casez ({cs_n, ras_n, cas_n, we_n})
            4'b1???: cmd = CMD_DESEL;
            4'b0111: cmd = CMD_NOP;
            4'b0011: cmd = CMD_ACT;
            4'b0101: cmd = CMD_RD;
            4'b0100: cmd = CMD_WR;
            4'b0010: cmd = CMD_PRE;
            4'b0000: cmd = CMD_LMR;
            default: cmd = CMD_OTHER;
        endcase
    end
endmodule

// File: rtl/ddr_bank_track.sv
// Module: ddr_bank_track
// Keeps one open-row bit per bank, updated from ACTIVE and PRECHARGE.
// Assumes: the commands arrive already decoded; the all-banks bit is
// passed in separately from the address bus.
module ddr_bank_track
    import ddr_chk_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BA_W = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [BA_W-1:0]  ba,
    input  logic             all_banks,
    output logic [NBANK-1:0] open_q
);
    // Set the bank bit on ACTIVE; clear one bit or all bits on PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else begin
            case (cmd)
                CMD_ACT: open_q[ba] <= 1'b1;
                CMD_PRE: begin
                    if (all_banks) open_q <= '0;
                    else           open_q[ba] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ACT |=> open_q[$past(ba)]);
    assert_pre_all_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && all_banks) |=> open_q == '0);
endmodule

// File: rtl/ddr_mode_track.sv
// Module: ddr_mode_track
// Tracks the gap after a mode load, the decoded extended-register settings
// and the lock window after the DLL is switched on.
// Assumes: TMRD >= 1 and TLOCK >= 1; ba == 1 targets the extended register.
module ddr_mode_track
    import ddr_chk_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int TMRD   = 2,
    parameter int TLOCK  = 200,
    localparam int MRD_W  = $clog2(TMRD + 1),
    localparam int LOCK_W = $clog2(TLOCK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              mrd_busy,
    output logic              lock_busy,
    output logic              rsvd_hit,
    output logic              dll_en_q,
    output logic              drv_red_q
);
    logic              ext_load;
    logic              dll_turn_on;
    logic [MRD_W-1:0]  mrd_cnt;
    logic [LOCK_W-1:0] lock_cnt;

    // Classify the current load and look at its reserved bits.
    always_comb begin
        ext_load    = (cmd == CMD_LMR) && (ba == BA_W'(1));
        dll_turn_on = ext_load && !addr[0] && !dll_en_q;
        rsvd_hit    = ext_load && (|addr[ADDR_W-1:2]);
        mrd_busy    = (mrd_cnt != '0);
        lock_busy   = dll_en_q && (lock_cnt != '0);
    end

    // Count down the cycles that must pass after any mode load.
    always_ff @(posedge clk) begin
        if (!rst_n)                mrd_cnt <= '0;
        else if (cmd == CMD_LMR)   mrd_cnt <= MRD_W'(TMRD - 1);
        else if (mrd_cnt != '0)    mrd_cnt <= mrd_cnt - 1'b1;
    end

    // Latch the DLL and drive fields written to the extended register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll_en_q  <= 1'b0;
            drv_red_q <= 1'b0;
        end else if (ext_load) begin
            dll_en_q  <= !addr[0];
            drv_red_q <= addr[1];
        end
    end

    // Start the lock window when the DLL goes from disabled to enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                lock_cnt <= '0;
        else if (dll_turn_on)      lock_cnt <= LOCK_W'(TLOCK - 1);
        else if (lock_cnt != '0)   lock_cnt <= lock_cnt - 1'b1;
    end

    assert_emr_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_load |=> (dll_en_q == !$past(addr[0])) && (drv_red_q == $past(addr[1])));
    assert_base_load_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR && ba != BA_W'(1)) |=> $stable(dll_en_q) && $stable(drv_red_q));
endmodule

// File: rtl/ddr_cmd_checker.sv
// Module: ddr_cmd_checker (top)
// Watches a DDR SDRAM command bus and latches the first sequencing violation.
// Assumes: a single rank; commands are sampled on every rising clock edge;
// violating commands still update the tracked state.
module ddr_cmd_checker
    import ddr_chk_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int TMRD   = 2,
    parameter int TLOCK  = 200,
    localparam int BA_W  = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_err,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_flag,
    output logic [2:0]        err_code,
    output logic [NBANK-1:0]  bank_open,
    output logic              dll_enabled,
    output logic              drive_reduced
);
    cmd_e cmd;
    logic mrd_busy, lock_busy, rsvd_hit;
    logic exec_cmd;
    err_e new_err;

    ddr_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    ddr_bank_track #(.NBANK(NBANK)) u_bank (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba),
        .all_banks(addr[AP_BIT]), .open_q(bank_open)
    );

    ddr_mode_track #(.ADDR_W(ADDR_W), .BA_W(BA_W), .TMRD(TMRD), .TLOCK(TLOCK)) u_mode (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .addr(addr),
        .mrd_busy(mrd_busy), .lock_busy(lock_busy), .rsvd_hit(rsvd_hit),
        .dll_en_q(dll_enabled), .drv_red_q(drive_reduced)
    );

    // Pick the highest-priority rule broken by this cycle's command.
    always_comb begin
        exec_cmd = (cmd != CMD_DESEL) && (cmd != CMD_NOP);
        if (exec_cmd && mrd_busy)
            new_err = ERR_MRD_GAP;
        else if (cmd == CMD_LMR && (|bank_open))
            new_err = ERR_LMR_BUSY;
        else if (rsvd_hit)
            new_err = ERR_EMR_RSVD;
        else if ((cmd == CMD_RD || cmd == CMD_WR) && !bank_open[ba])
            new_err = ERR_BANK_CLOSED;
        else if (cmd == CMD_RD && lock_busy)
            new_err = ERR_DLL_LOCK;
        else
            new_err = ERR_NONE;
    end

    // Hold the first violation until cleared; the clear takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_err) begin
            err_flag <= 1'b0;
            err_code <= 3'd0;
        end else if (!err_flag && new_err != ERR_NONE) begin
            err_flag <= 1'b1;
            err_code <= new_err;
        end
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> err_flag && $stable(err_code));
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> !err_flag);
    assert_closed_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && !bank_open[ba] && !err_flag && !clr_err)
        |=> err_flag);
    assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR && bank_open != '0 && !err_flag && !clr_err) |=> err_flag);
    assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_cmd && mrd_busy && !err_flag && !clr_err) |=> err_code == 3'd2);
    assert_lock_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD && lock_busy && !err_flag && !clr_err) |=> err_flag);
    assert_idle_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_cmd && !err_flag && !clr_err) |=> !err_flag);
endmodule

// File: tb/sim_ddr_cmd_checker.sv
`timescale 1ns/1ps
module sim_ddr_cmd_checker;
    localparam int TMRD  = 2;
    localparam int TLOCK = 200;
    localparam logic [3:0] OP_DES = 4'b1111, OP_NOP = 4'b0111, OP_ACT = 4'b0011,
                           OP_RD  = 4'b0101, OP_WR  = 4'b0100, OP_PRE = 4'b0010,
                           OP_LMR = 4'b0000, OP_REF = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_err = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [12:0] addr = '0;
    logic err_flag;
    logic [2:0] err_code;
    logic [3:0] bank_open;
    logic dll_enabled, drive_reduced;

    int checks = 0;
    int errors = 0;

    // Reference model state, kept as plain integers and cycle stamps.
    int cyc = 0;
    int last_lmr = -1000;
    int en_cyc = -1000;
    logic [3:0] m_open = '0;
    bit m_dll = 0, m_drv = 0, m_flag = 0;
    int m_code = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_checker #(.TMRD(TMRD), .TLOCK(TLOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr),
        .err_flag(err_flag), .err_code(err_code), .bank_open(bank_open),
        .dll_enabled(dll_enabled), .drive_reduced(drive_reduced)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (step %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic model_apply(input logic [3:0] op, input logic [1:0] b,
                               input logic [12:0] a, input logic clr);
        bit is_exec, is_lmr, is_act, is_rd, is_wr, is_pre;
        int code;
        is_exec = !op[3] && (op[2:0] != 3'b111);
        is_lmr  = (op == OP_LMR);
        is_act  = (op == OP_ACT);
        is_rd   = (op == OP_RD);
        is_wr   = (op == OP_WR);
        is_pre  = (op == OP_PRE);
        code = 0;
        if (is_exec && (cyc - last_lmr) < TMRD) code = 2;
        else if (is_lmr && m_open != 0) code = 1;
        else if (is_lmr && b == 2'd1 && a[12:2] != 0) code = 4;
        else if ((is_rd || is_wr) && !m_open[b]) code = 5;
        else if (is_rd && m_dll && (cyc - en_cyc) < TLOCK) code = 3;
        if (clr) begin
            m_flag = 0; m_code = 0;
        end else if (!m_flag && code != 0) begin
            m_flag = 1; m_code = code;
        end
        if (is_act) m_open[b] = 1'b1;
        if (is_pre) begin
            if (a[10]) m_open = '0;
            else       m_open[b] = 1'b0;
        end
        if (is_lmr) begin
            last_lmr = cyc;
            if (b == 2'd1) begin
                if (!a[0] && !m_dll) en_cyc = cyc;
                m_dll = !a[0];
                m_drv = a[1];
            end
        end
        cyc++;
    endtask

    // Drive one command, let one edge pass, then compare against the model.
    task automatic step(input logic [3:0] op, input logic [1:0] b, input logic [12:0] a,
                        input logic clr, input string tag);
        {cs_n, ras_n, cas_n, we_n} = op;
        ba = b; addr = a; clr_err = clr;
        @(posedge clk);
        @(negedge clk);
        model_apply(op, b, a, clr);
        chk(tag, "err_flag", int'(err_flag), int'(m_flag));
        chk(tag, "err_code", int'(err_code), m_code);
        chk("R3", "bank_open", int'(bank_open), int'(m_open));
        chk("R7", "dll_enabled", int'(dll_enabled), int'(m_dll));
        chk("R7", "drive_reduced", int'(drive_reduced), int'(m_drv));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(OP_NOP, 2'd0, 13'h0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "err_flag", int'(err_flag), 0);
        chk("R1", "err_code", int'(err_code), 0);
        chk("R1", "bank_open", int'(bank_open), 0);
        chk("R1", "dll_enabled", int'(dll_enabled), 0);
        chk("R1", "drive_reduced", int'(drive_reduced), 0);

        // R2: deselect with garbage on the other lines, then NOP
        step(OP_DES, 2'd2, 13'h1fff, 1'b0, "R2");
        step(4'b1000, 2'd3, 13'h0400, 1'b0, "R2");
        step(OP_NOP, 2'd1, 13'h1fff, 1'b0, "R2");
        // R7: enable DLL, normal drive; NOP and deselect inside the gap are legal (R2)
        step(OP_LMR, 2'd1, 13'h0000, 1'b0, "R7");
        step(OP_NOP, 2'd0, 13'h0, 1'b0, "R2");
        step(OP_DES, 2'd0, 13'h0, 1'b0, "R2");
        // R9: READ well inside the lock window; R10: later WRITE to a closed bank keeps code
        step(OP_ACT, 2'd0, 13'h0123, 1'b0, "R3");
        step(OP_RD, 2'd0, 13'h0, 1'b0, "R9");
        step(OP_WR, 2'd2, 13'h0, 1'b0, "R10");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");
        idle(200, "R2");
        step(OP_RD, 2'd0, 13'h0, 1'b0, "R9");
        // R4: write to a closed bank
        step(OP_WR, 2'd2, 13'h0, 1'b0, "R4");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");
        // R3: single-bank precharge; R5: load with a bank open
        step(OP_ACT, 2'd1, 13'h0, 1'b0, "R3");
        step(OP_PRE, 2'd0, 13'h0000, 1'b0, "R3");
        step(OP_LMR, 2'd0, 13'h0, 1'b0, "R5");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");
        step(OP_PRE, 2'd2, 13'h0400, 1'b0, "R3");
        idle(2, "R2");
        // R6: executable command right after a load
        step(OP_LMR, 2'd0, 13'h0, 1'b0, "R6");
        step(OP_ACT, 2'd0, 13'h0, 1'b0, "R6");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");
        step(OP_PRE, 2'd0, 13'h0400, 1'b0, "R3");
        idle(2, "R2");
        // R7: disable DLL, reduced drive; base and undefined targets change nothing
        step(OP_LMR, 2'd1, 13'h0003, 1'b0, "R7");
        idle(2, "R7");
        step(OP_LMR, 2'd0, 13'h0000, 1'b0, "R7");
        idle(2, "R7");
        step(OP_LMR, 2'd2, 13'h0000, 1'b0, "R7");
        idle(2, "R7");
        step(OP_LMR, 2'd3, 13'h0001, 1'b0, "R7");
        idle(2, "R7");
        // R8: reserved bit set in an extended load
        step(OP_LMR, 2'd1, 13'h0020, 1'b0, "R8");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");
        idle(2, "R2");
        // R10: clear wins over a violation, then priority of gap over busy bank
        step(OP_ACT, 2'd3, 13'h0, 1'b0, "R3");
        step(OP_LMR, 2'd0, 13'h0, 1'b1, "R10");
        step(OP_LMR, 2'd0, 13'h0, 1'b0, "R10");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");
        step(OP_PRE, 2'd0, 13'h0400, 1'b0, "R3");
        idle(2, "R2");
        // R9: READ exactly TLOCK cycles after enable is legal
        step(OP_LMR, 2'd1, 13'h0001, 1'b0, "R7");
        idle(2, "R2");
        step(OP_LMR, 2'd1, 13'h0000, 1'b0, "R9");
        step(OP_NOP, 2'd0, 13'h0, 1'b0, "R2");
        step(OP_ACT, 2'd0, 13'h0, 1'b0, "R3");
        idle(TLOCK - 3, "R2");
        step(OP_RD, 2'd0, 13'h0, 1'b0, "R9");
        // R9: READ at TLOCK-1 cycles after enable is a violation
        step(OP_PRE, 2'd0, 13'h0400, 1'b0, "R3");
        idle(2, "R2");
        step(OP_LMR, 2'd1, 13'h0001, 1'b0, "R7");
        idle(2, "R2");
        step(OP_LMR, 2'd1, 13'h0000, 1'b0, "R9");
        step(OP_NOP, 2'd0, 13'h0, 1'b0, "R2");
        step(OP_ACT, 2'd0, 13'h0, 1'b0, "R3");
        idle(TLOCK - 4, "R2");
        step(OP_RD, 2'd0, 13'h0, 1'b0, "R9");
        step(OP_NOP, 2'd0, 13'h0, 1'b1, "R10");

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic [12:0] a;
            case ($urandom_range(0, 9))
                0: op = OP_DES;
                1, 2, 9: op = OP_NOP;
                3: op = OP_ACT;
                4: op = OP_RD;
                5: op = OP_WR;
                6: op = OP_PRE;
                7: op = OP_LMR;
                default: op = OP_REF;
            endcase
            a = 13'($urandom);
            if ($urandom_range(0, 7) != 0) a = a & 13'h0403;
            step(op, 2'($urandom), a, ($urandom_range(0, 15) == 0), "R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule